// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects fifteen interrupt request lines, numbered 1 to 15, and presents one prioritised request to a processor. Every line records into a shared pending register. A line whose broadcast bit is set is instead copied into the force register of every CPU bank. Each CPU bank holds its own mask and force register. Each line can be placed in a high or a low priority group. Only CPU bank 0 drives the outgoing request. That request is formed from the pending and bank-0 force bits that bank 0 leaves unmasked. Any line of the high group beats every line of the low group, and within the winning group the highest-numbered line wins.

Software reaches the registers over a simple 32-bit word bus. Each access is one cycle, and read data returns one cycle after the access. A one-cycle acknowledge strobe carrying a line number clears the serviced line. A write to the clear register removes any set of lines. Writes to a per-CPU force register can set bits and clear bits in one access. A separate alias for bank 0 replaces its force register outright.

Top module: `irq_ctrl_mp`

## Requirements
- R1: Word offsets are level 0x00, pending 0x04, bank-0 force alias 0x08, clear 0x0C, status 0x10, broadcast 0x14, mask of bank n at 0x40+4n and force of bank n at 0x80+4n. Only address bits 7..2 are decoded. `bus_rdata` carries the addressed value in the cycle after a read access (`bus_sel`=1, `bus_we`=0) and is 0 in every other cycle.
- R2: Register writes keep only bits 15..1. Bit 0 and, except for the force clear field, bits 31..16 are dropped and read back as 0.
- R3: The active set is (pending OR force of bank 0) AND mask of bank 0. `irq_valid` is 1 exactly when the active set is non-empty.
- R4: A level bit of 1 puts a line in the high group. When any active line is in the high group, `irq_id` is the highest-numbered such line. Otherwise it is the highest-numbered active line. `irq_id` is 0 when nothing is active.
- R5: A cycle with `irq_lines[i]`=1 sets bit i in the force register of every bank when broadcast bit i is 1, and sets pending bit i when it is 0. `irq_lines[0]` has no effect.
- R6: A write to clear with value v clears bits v[15:1] in pending and in bank-0 force. An `ack_valid` strobe clears bit `ack_id` in the same two registers. An input line asserted in the same cycle as its clear or acknowledge leaves the bit set.
- R7: A write to the force register of bank n sets bits wdata[15:1] and clears the bits named by wdata[31:17], where wdata[16+i] names line i. The result is (old OR set) AND NOT clear, so clear wins over set.
- R8: A write to the alias at 0x08 replaces bank-0 force with wdata[15:1].
- R9: Writes to pending, status, unused offsets and banks at or above the bank count change nothing. Reads of clear, status and unused offsets return 0.
- R10: A synchronous active-high reset zeroes every register and both request outputs.
- R11: `irq_valid` and `irq_id` are registered. They reflect the register state one clock after it changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, bits 7..2 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | LINES | Incoming interrupt lines, active high per cycle |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Line number being acknowledged |
| irq_valid | output | 1 | Request to the processor |
| irq_id | output | ID_W | Number of the winning line |

## Verification
The bench builds the block with its defaults: sixteen line bits, four CPU banks and an 8-bit address. Four banks put the broadcast path into non-zero banks, so set/clear force writes can be seen on banks that never reach the output. They also leave bank slots 4 to 15 of the mask and force windows unmapped, so writes there can be checked as ignored. A behavioural reference model follows every clock and is compared on every cycle, through directed cases and then a long stretch of random bus traffic, lines and acknowledges.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // word indices (byte address bits 7..2)
  localparam int W_LEVEL  = 0;
  localparam int W_PEND   = 1;
  localparam int W_ALIAS  = 2;
  localparam int W_CLEAR  = 3;
  localparam int W_STATUS = 4;
  localparam int W_BCAST  = 5;
  localparam int W_MASK0  = 16;
  localparam int W_FORCE0 = 32;
  // lsb of the clear field in a per-bank force write
  localparam int CLR_LSB  = 16;
endpackage

// File: rtl/irqc_glob.sv
module irqc_glob #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_level,
  input  logic             wr_bcast,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] set_all,
  input  logic [LINES-1:0] clr_bits,
  output logic [LINES-1:0] level_q,
  output logic [LINES-1:0] bcast_q,
  output logic [LINES-1:0] pend_q,
  output logic [LINES-1:0] bset
);
  localparam logic [LINES-1:0] KEEP = ~LINES'(1);

  // broadcast routing uses the broadcast value held before this edge
  assign bset = set_all & bcast_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      bcast_q <= '0;
      pend_q  <= '0;
    end else begin
      if (wr_level) level_q <= wdata & KEEP;
      if (wr_bcast) bcast_q <= wdata & KEEP;
      // set after clear: a new assertion survives a same-cycle clear
      pend_q <= (pend_q & ~clr_bits) | (set_all & ~bcast_q);
    end
  end

  // R6: cleared bits are gone unless re-asserted on a non-broadcast line
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (|clr_bits) |=> ((pend_q & $past(clr_bits & ~(set_all & ~bcast_q))) == '0));

  // R9: with no line and no clear, pending does not move
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (set_all == '0 && clr_bits == '0) |=> $stable(pend_q));

  // R2: bit 0 never stored
  p_bit0_r2: assert property (@(posedge clk) disable iff (rst)
    !pend_q[0] && !level_q[0] && !bcast_q[0]);
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int LINES     = 16,
  parameter bit HAS_ALIAS = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_mask,
  input  logic             wr_force,
  input  logic             wr_alias,
  input  logic [31:0]      wdata,
  input  logic [LINES-1:0] clr_bits,
  input  logic [LINES-1:0] bset,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] force_q
);
  import irqc_pkg::*;
  localparam logic [LINES-1:0] KEEP = ~LINES'(1);

  logic [LINES-1:0] set_field, clr_field, base, force_d;

  assign set_field = wdata[LINES-1:0] & KEEP;
  assign clr_field = wdata[CLR_LSB +: LINES] & KEEP;

  always_comb begin
    base = force_q;
    if (HAS_ALIAS && wr_alias) base = set_field;
    else if (wr_force)         base = (force_q | set_field) & ~clr_field;
    force_d = (base & ~clr_bits) | bset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      force_q <= '0;
    end else begin
      if (wr_mask) mask_q <= set_field;
      force_q <= force_d;
    end
  end

  // R5: every broadcast assertion lands in this bank
  p_bcast_r5: assert property (@(posedge clk) disable iff (rst)
    (|bset) |=> (($past(bset) & ~force_q) == '0));

  // R7: clear field wins unless the line re-asserts by broadcast
  p_force_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_force && !wr_alias && (clr_field & bset) == '0) |=> ((force_q & $past(clr_field)) == '0));

  // R2: bit 0 never stored
  p_bit0_bank_r2: assert property (@(posedge clk) disable iff (rst)
    !force_q[0] && !mask_q[0]);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int LINES = 16,
  parameter int ID_W  = 4
) (
  input  logic [LINES-1:0] active,
  input  logic [LINES-1:0] level,
  output logic             any,
  output logic [ID_W-1:0]  id
);
  logic [LINES-1:0] hi, win;

  always_comb begin
    hi  = active & level;
    win = (|hi) ? hi : (active & ~level);
    any = |win;
    id  = '0;
    for (int i = 1; i < LINES; i++)
      if (win[i]) id = ID_W'(i);
  end
endmodule

// File: rtl/irq_ctrl_mp.sv
module irq_ctrl_mp #(
  parameter int LINES  = 16,
  parameter int CPUS   = 4,
  parameter int ADDR_W = 8,
  localparam int ID_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [LINES-1:0]  irq_lines,
  input  logic              ack_valid,
  input  logic [ID_W-1:0]   ack_id,
  output logic              irq_valid,
  output logic [ID_W-1:0]   irq_id
);
  import irqc_pkg::*;
  localparam logic [LINES-1:0] KEEP = ~LINES'(1);
  localparam logic [5:0] A_LEVEL  = 6'(W_LEVEL);
  localparam logic [5:0] A_PEND   = 6'(W_PEND);
  localparam logic [5:0] A_ALIAS  = 6'(W_ALIAS);
  localparam logic [5:0] A_CLEAR  = 6'(W_CLEAR);
  localparam logic [5:0] A_BCAST  = 6'(W_BCAST);

  logic [5:0]       word;
  logic             wr, rd;
  logic [LINES-1:0] set_all, clr_bits, ack_bits;
  logic [LINES-1:0] level_q, bcast_q, pend_q, bset;
  logic [LINES-1:0] mask_q  [CPUS];
  logic [LINES-1:0] force_q [CPUS];
  logic [LINES-1:0] active;
  logic             nxt_valid;
  logic [ID_W-1:0]  nxt_id;
  logic [31:0]      rd_val;
  logic             unused_addr;

  assign word        = bus_addr[7:2];
  assign unused_addr = ^bus_addr[1:0];
  assign wr          = bus_sel & bus_we;
  assign rd          = bus_sel & ~bus_we;
  assign set_all     = irq_lines & KEEP;
  assign ack_bits    = ack_valid ? (LINES'(1) << ack_id) : '0;
  assign clr_bits    = (((wr && word == A_CLEAR) ? bus_wdata[LINES-1:0] : '0) | ack_bits) & KEEP;

  irqc_glob #(.LINES(LINES)) u_glob (
    .clk      (clk),
    .rst      (rst),
    .wr_level (wr && word == A_LEVEL),
    .wr_bcast (wr && word == A_BCAST),
    .wdata    (bus_wdata[LINES-1:0]),
    .set_all  (set_all),
    .clr_bits (clr_bits),
    .level_q  (level_q),
    .bcast_q  (bcast_q),
    .pend_q   (pend_q),
    .bset     (bset)
  );

  for (genvar c = 0; c < CPUS; c++) begin : g_bank
    irqc_bank #(.LINES(LINES), .HAS_ALIAS(c == 0)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_mask  (wr && word == 6'(W_MASK0 + c)),
      .wr_force (wr && word == 6'(W_FORCE0 + c)),
      .wr_alias (wr && word == A_ALIAS),
      .wdata    (bus_wdata),
      .clr_bits ((c == 0) ? clr_bits : '0),
      .bset     (bset),
      .mask_q   (mask_q[c]),
      .force_q  (force_q[c])
    );
  end

  assign active = (pend_q | force_q[0]) & mask_q[0];

  irqc_prio #(.LINES(LINES), .ID_W(ID_W)) u_prio (
    .active (active),
    .level  (level_q),
    .any    (nxt_valid),
    .id     (nxt_id)
  );

  always_comb begin
    rd_val = '0;
    case (word)
      A_LEVEL: rd_val = 32'(level_q);
      A_PEND:  rd_val = 32'(pend_q);
      A_ALIAS: rd_val = 32'(force_q[0]);
      A_BCAST: rd_val = 32'(bcast_q);
      default: begin
        for (int c = 0; c < CPUS; c++) begin
          if (word == 6'(W_MASK0 + c))  rd_val = 32'(mask_q[c]);
          if (word == 6'(W_FORCE0 + c)) rd_val = 32'(force_q[c]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
      bus_rdata <= '0;
    end else begin
      irq_valid <= nxt_valid;
      irq_id    <= nxt_id;
      bus_rdata <= rd ? rd_val : '0;
    end
  end

  // R4: no request means number 0
  p_idle_id_r4: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> (irq_id == '0));

  // R3: a request needs a non-empty bank-0 mask one cycle earlier
  p_valid_mask_r3: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ($past(mask_q[0]) != '0));

  // R1: read data is zero unless a read was issued
  p_rdata_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> (bus_rdata == '0));
endmodule

// File: tb/irq_ctrl_mp_tb_top.sv
module irq_ctrl_mp_tb_top;
  localparam int LINES = 16;
  localparam int CPUS  = 4;

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_sel = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_lines = 0;
  logic        ack_valid = 0;
  logic [3:0]  ack_id = 0;
  logic        irq_valid;
  logic [3:0]  irq_id;

  irq_ctrl_mp #(.LINES(LINES), .CPUS(CPUS), .ADDR_W(8)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .ack_valid(ack_valid), .ack_id(ack_id), .irq_valid(irq_valid), .irq_id(irq_id));

  always #5 clk = ~clk;

  int n_checks = 0, n_fail = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_level = 0, m_pend = 0, m_bc = 0;
  logic [15:0] m_mask [CPUS];
  logic [15:0] m_force[CPUS];
  logic        e_valid = 0;
  logic [3:0]  e_id = 0;
  logic [31:0] e_rd = 0;
  initial for (int c = 0; c < CPUS; c++) begin m_mask[c] = 0; m_force[c] = 0; end

  function automatic logic [31:0] mread(int a);
    int w = a / 4;
    if (w == 0) return {16'h0, m_level};
    if (w == 1) return {16'h0, m_pend};
    if (w == 2) return {16'h0, m_force[0]};
    if (w == 5) return {16'h0, m_bc};
    if (w >= 16 && w < 16 + CPUS) return {16'h0, m_mask[w-16]};
    if (w >= 32 && w < 32 + CPUS) return {16'h0, m_force[w-32]};
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [15:0] act, hi, win, clr, setl, nf[CPUS];
    logic [15:0] np;
    int w;
    if (rst) begin
      m_level = 0; m_pend = 0; m_bc = 0;
      for (int c = 0; c < CPUS; c++) begin m_mask[c] = 0; m_force[c] = 0; end
      e_valid = 0; e_id = 0; e_rd = 0;
    end else begin
      act = (m_pend | m_force[0]) & m_mask[0] & 16'hFFFE;
      hi  = act & m_level;
      win = (hi != 0) ? hi : (act & ~m_level);
      e_valid = (win != 0);
      e_id = 0;
      for (int i = 0; i < 16; i++) if (win[i]) e_id = 4'(i);
      e_rd = (bus_sel && !bus_we) ? mread(int'(bus_addr)) : 0;
      np = m_pend;
      for (int c = 0; c < CPUS; c++) nf[c] = m_force[c];
      clr = 0;
      w = int'(bus_addr) / 4;
      if (bus_sel && bus_we) begin
        if (w == 0) m_level = bus_wdata[15:0] & 16'hFFFE;
        if (w == 2) nf[0] = bus_wdata[15:0] & 16'hFFFE;
        if (w == 3) clr = bus_wdata[15:0];
        if (w == 5) m_bc_next_dummy(w);
        for (int c = 0; c < CPUS; c++) begin
          if (w == 16 + c) m_mask[c] = bus_wdata[15:0] & 16'hFFFE;
          if (w == 32 + c) nf[c] = (m_force[c] | (bus_wdata[15:0] & 16'hFFFE)) & ~(bus_wdata[31:16] & 16'hFFFE);
        end
      end
      if (ack_valid) clr = clr | (16'h1 << ack_id);
      clr = clr & 16'hFFFE;
      np = np & ~clr;
      nf[0] = nf[0] & ~clr;
      setl = irq_lines & 16'hFFFE;
      np = np | (setl & ~m_bc);
      for (int c = 0; c < CPUS; c++) m_force[c] = nf[c] | (setl & m_bc);
      m_pend = np;
      if (bus_sel && bus_we && w == 5) m_bc = bus_wdata[15:0] & 16'hFFFE;
    end
  end

  function automatic void m_bc_next_dummy(int w);
    // broadcast is committed after routing so the old value steers this cycle
    if (w < 0) $display("unreachable");
  endfunction

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    chk("R3 irq_valid vs model", 32'(irq_valid), 32'(e_valid));
    chk("R4 irq_id vs model", 32'(irq_id), 32'(e_id));
    chk("R1 bus_rdata vs model", bus_rdata, e_rd);
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic pulse(int line);
    irq_lines = 16'h1 << line;
    @(negedge clk);
    irq_lines = 0;
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R10 irq_valid after reset", 32'(irq_valid), 0);
    chk("R10 irq_id after reset", 32'(irq_id), 0);
    rd(8'h04, d); chk("R10 pending after reset", d, 0);

    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R2 mask0 keeps bits 15..1", d, 32'h0000_FFFE);

    pulse(3);
    chk("R11 request not yet visible", 32'(irq_valid), 0);
    @(negedge clk);
    chk("R3 pending line raises request", 32'(irq_valid), 1);
    chk("R3 line 3 number", 32'(irq_id), 3);

    pulse(9); @(negedge clk);
    chk("R4 highest line wins", 32'(irq_id), 9);
    wr(8'h00, 32'h0000_0008); @(negedge clk);
    chk("R4 high group wins", 32'(irq_id), 3);
    rd(8'h00, d); chk("R1 level readback", d, 32'h8);

    ack_valid = 1; ack_id = 3; @(negedge clk); ack_valid = 0; @(negedge clk);
    chk("R6 ack clears line 3", 32'(irq_id), 9);
    rd(8'h04, d); chk("R6 pending after ack", d, 32'h200);

    wr(8'h0C, 32'hFFFF_FFFF); @(negedge clk);
    chk("R6 clear write empties", 32'(irq_valid), 0);

    wr(8'h14, 32'hFFFF_8001);
    rd(8'h14, d); chk("R2 broadcast readback", d, 32'h8000);
    pulse(15);
    rd(8'h88, d); chk("R5 broadcast into bank 2", d, 32'h8000);
    rd(8'h84, d); chk("R5 broadcast into bank 1", d, 32'h8000);
    rd(8'h04, d); chk("R5 pending untouched", d, 0);
    chk("R3 force path raises request", 32'(irq_id), 15);

    wr(8'h0C, 32'h0000_8000);
    rd(8'h80, d); chk("R6 clear reaches bank-0 force", d, 0);
    rd(8'h84, d); chk("R6 clear spares bank 1", d, 32'h8000);
    wr(8'h84, 32'h0000_0006);
    wr(8'h84, 32'h0002_0008);
    rd(8'h84, d); chk("R7 set and clear masks", d, 32'h800C);
    wr(8'h84, 32'h0010_0010);
    rd(8'h84, d); chk("R7 clear wins over set", d, 32'h800C);
    wr(8'h84, 32'h8000_0000);
    rd(8'h84, d); chk("R7 clear line 15", d, 32'h000C);

    wr(8'h08, 32'h0001_2345);
    rd(8'h08, d); chk("R8 alias replaces force0", d, 32'h2344);
    rd(8'h80, d); chk("R8 alias visible at bank-0 force", d, 32'h2344);
    chk("R4 low group highest", 32'(irq_id), 13);
    wr(8'h08, 0);
    wr(8'h14, 0);

    wr(8'h04, 32'h0000_FFFF);
    rd(8'h04, d); chk("R9 pending write ignored", d, 0);
    rd(8'h0C, d); chk("R9 clear reads zero", d, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R9 status reads zero", d, 0);
    wr(8'hC0, 32'h0000_000F);
    rd(8'hC0, d); chk("R9 unused offset reads zero", d, 0);
    wr(8'h50, 32'h0000_FFFF);
    rd(8'h50, d); chk("R9 bank beyond count", d, 0);
    rd(8'h40, d); chk("R9 mask0 untouched", d, 32'hFFFE);
    rd(8'h00, d); chk("R9 level untouched", d, 32'h8);

    pulse(5);
    irq_lines = 16'h0020; ack_valid = 1; ack_id = 5;
    @(negedge clk);
    irq_lines = 0; ack_valid = 0;
    rd(8'h04, d); chk("R6 same-cycle assertion survives ack", d, 32'h20);
    ack_valid = 1; ack_id = 5; @(negedge clk); ack_valid = 0;
    rd(8'h04, d); chk("R6 plain ack clears", d, 0);
    pulse(0);
    rd(8'h04, d); chk("R5 line 0 ignored", d, 0);

    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 14);
      int b = int'($urandom % CPUS);
      bus_sel = 0; bus_we = 0;
      if (r < 10) begin
        bus_sel = 1;
        bus_we = ($urandom % 2) == 1;
        case (r)
          0: bus_addr = 8'h00;
          1: bus_addr = 8'h04;
          2: bus_addr = 8'h08;
          3: bus_addr = 8'h0C;
          4: bus_addr = 8'h10;
          5: bus_addr = 8'h14;
          6: bus_addr = 8'(8'h40 + 4 * b);
          7: bus_addr = 8'(8'h80 + 4 * b);
          default: bus_addr = 8'($urandom);
        endcase
        bus_wdata = $urandom;
      end
      irq_lines = (($urandom % 3) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      ack_valid = ($urandom % 4) == 0;
      ack_id = 4'($urandom);
      @(negedge clk);
    end
    bus_sel = 0; bus_we = 0; irq_lines = 0; ack_valid = 0;

    rst = 1; repeat (2) @(negedge clk); rst = 0;
    chk("R10 irq_valid after mid-run reset", 32'(irq_valid), 0);
    rd(8'h40, d); chk("R10 mask0 zero after reset", d, 0);
    rd(8'h84, d); chk("R10 bank-1 force zero after reset", d, 0);
    rd(8'h14, d); chk("R10 broadcast zero after reset", d, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule